// File: doc/BRIEF.md
# Test-Access Data Register Selector

This block sits behind a standard IEEE 1149.1 TAP controller. It holds the current instruction and, from it and the TAP's capture, shift and update strobes, decides which data register sits between TDI and TDO. The three candidates are a boundary-scan chain over a small set of pin cells, a one-bit core reset register and the one-bit bypass register. The TAP state machine is outside the block and appears only as input strobes, all sampled on the rising edge of `tck`.

The boundary-scan chain samples the external pin values on capture. It shifts on shift, and on update it copies its contents into a set of output latches. Those latches are brought out, but they never drive the pins, so sampling and preloading leave the system running undisturbed. The reset register has no update stage: the bit it holds is the core reset request. The core stays in reset for as long as a one sits in that register, while the TAP itself keeps working. The TAP's test-logic-reset strobe returns the instruction to bypass and clears the reset register.

There is no streaming data path, so all pins are plain control and status signals. At most one of the capture, shift and update strobes is expected high in any cycle.

Top module: `jtag_dr_select`

## Requirements
- R1: After `rst_n` is released, the instruction is bypass (0xF), `core_rst_req` is 0, `latch_out` is all zeros and `tdo` is 0.
- R2: With instruction 0x2 selected, a capture-DR cycle loads `pin_in` into the boundary-scan chain, and `tdo` then shows `pin_in[0]`.
- R3: With instruction 0x2 selected, each shift-DR cycle moves the chain one place toward bit 0 and puts `tdi` into the top bit. `tdo` always shows chain bit 0.
- R4: With instruction 0x2 selected, an update-DR cycle copies the chain into `latch_out`. No other cycle changes `latch_out`.
- R5: With instruction 0xC selected, a shift-DR cycle loads `tdi` into the reset register, and `core_rst_req` equals that register from the same edge on. Capture-DR and update-DR have no effect on it.
- R6: `core_rst_req` keeps its value when the instruction is changed and during data-register activity aimed at other registers.
- R7: With instruction 0xF selected, capture-DR loads 0 into the bypass register, and shift-DR loads `tdi` into it. `tdo` shows the bypass register, so the data is delayed by one cycle.
- R8: Any instruction code other than 0x2 and 0xC acts as bypass.
- R9: A cycle with `tlr` high sets the instruction to 0xF and clears the reset register (releasing `core_rst_req`). It ignores all DR strobes and `ir_upd` in that cycle, and leaves `latch_out` unchanged.
- R10: A register that is not selected keeps its contents through capture, shift and update cycles aimed at another register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| tlr | input | 1 | Test-logic-reset strobe from the TAP |
| ir_upd | input | 1 | Update-IR strobe: load `ir_code` as the new instruction |
| ir_code | input | IR_W | Instruction value presented with `ir_upd` |
| cap_dr | input | 1 | Capture-DR strobe |
| shf_dr | input | 1 | Shift-DR strobe |
| upd_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial test data in |
| pin_in | input | N_PINS | Pin values seen by the boundary-scan cells |
| tdo | output | 1 | Serial test data out (bit 0 of the selected register) |
| latch_out | output | N_PINS | Boundary-scan output latches, not routed to pins |
| core_rst_req | output | 1 | Core reset request, equal to the reset register |

## Verification
The bench builds the block with `N_PINS` = 6 and the default 4-bit instruction width. A six-cell chain is long enough that the gap between a captured pattern and the bits shifted in behind it shows clearly at `tdo`. It is also short enough that random runs often complete full capture–shift–update passes, and then the update-DR copy into `latch_out` can be compared bit by bit. The 4-bit width puts the whole space of instruction codes within reach, so random loads hit the unrecognised codes as well as 0x2, 0xC and 0xF.

// File: rtl/jdr_pkg.sv
package jdr_pkg;
  typedef enum logic [1:0] {
    SEL_BYP = 2'd0,
    SEL_BSC = 2'd1,
    SEL_RST = 2'd2
  } dr_sel_e;
endpackage

// File: rtl/jdr_ir_decode.sv
module jdr_ir_decode #(
  parameter int unsigned IR_W = 4,
  parameter logic [IR_W-1:0] CODE_BSC = 4'h2,
  parameter logic [IR_W-1:0] CODE_RST = 4'hC,
  parameter logic [IR_W-1:0] CODE_BYP = 4'hF
) (
  input  logic                  tck,
  input  logic                  rst_n,
  input  logic                  tlr,
  input  logic                  ir_upd,
  input  logic [IR_W-1:0]       ir_code,
  output logic [IR_W-1:0]       instr_q,
  output jdr_pkg::dr_sel_e      sel
);
  // instruction register: test-logic-reset wins over a new load
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)       instr_q <= CODE_BYP;
    else if (tlr)     instr_q <= CODE_BYP;
    else if (ir_upd)  instr_q <= ir_code;
  end

  // decode; every unknown code falls back to bypass
  always_comb begin
    if (instr_q == CODE_BSC)      sel = jdr_pkg::SEL_BSC;
    else if (instr_q == CODE_RST) sel = jdr_pkg::SEL_RST;
    else                          sel = jdr_pkg::SEL_BYP;
  end
endmodule

// File: rtl/jdr_bscan_chain.sv
module jdr_bscan_chain #(
  parameter int unsigned N_PINS = 8
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              shf_en,
  input  logic              upd_en,
  input  logic              tdi,
  input  logic [N_PINS-1:0] pin_in,
  output logic              so,
  output logic [N_PINS-1:0] latch_out
);
  logic [N_PINS-1:0] cell_q;

  // per-cell capture/shift stage; the serial input enters at the top cell
  for (genvar g = 0; g < N_PINS; g++) begin : g_cell
    logic shift_src;
    if (g == N_PINS - 1) begin : g_top
      assign shift_src = tdi;
    end else begin : g_mid
      assign shift_src = cell_q[g+1];
    end

    always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)      cell_q[g] <= 1'b0;
      else if (cap_en) cell_q[g] <= pin_in[g];
      else if (shf_en) cell_q[g] <= shift_src;
    end

    // update latch: held output, kept away from the pins
    always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)      latch_out[g] <= 1'b0;
      else if (upd_en) latch_out[g] <= cell_q[g];
    end
  end

  assign so = cell_q[0];
endmodule

// File: rtl/jdr_onebit.sv
module jdr_onebit (
  input  logic tck,
  input  logic rst_n,
  input  logic clr,
  input  logic cap_en,
  input  logic shf_en,
  input  logic tdi,
  output logic q
);
  // capture loads a fixed zero; clear has top priority
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (clr)    q <= 1'b0;
    else if (cap_en) q <= 1'b0;
    else if (shf_en) q <= tdi;
  end
endmodule

// File: rtl/jtag_dr_select.sv
module jtag_dr_select #(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned IR_W   = 4,
  parameter logic [IR_W-1:0] CODE_BSC = 4'h2,
  parameter logic [IR_W-1:0] CODE_RST = 4'hC,
  parameter logic [IR_W-1:0] CODE_BYP = 4'hF
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              tlr,
  input  logic              ir_upd,
  input  logic [IR_W-1:0]   ir_code,
  input  logic              cap_dr,
  input  logic              shf_dr,
  input  logic              upd_dr,
  input  logic              tdi,
  input  logic [N_PINS-1:0] pin_in,
  output logic              tdo,
  output logic [N_PINS-1:0] latch_out,
  output logic              core_rst_req
);
  import jdr_pkg::*;

  logic [IR_W-1:0] cur_instr;
  dr_sel_e         sel;
  logic            live;
  logic            bsc_so, rst_q, byp_q;

  jdr_ir_decode #(
    .IR_W(IR_W), .CODE_BSC(CODE_BSC), .CODE_RST(CODE_RST), .CODE_BYP(CODE_BYP)
  ) u_dec (
    .tck(tck), .rst_n(rst_n), .tlr(tlr), .ir_upd(ir_upd), .ir_code(ir_code),
    .instr_q(cur_instr), .sel(sel)
  );

  // DR strobes are ignored during test-logic-reset
  assign live = !tlr;

  jdr_bscan_chain #(.N_PINS(N_PINS)) u_bsc (
    .tck(tck), .rst_n(rst_n),
    .cap_en(live && cap_dr && sel == SEL_BSC),
    .shf_en(live && shf_dr && sel == SEL_BSC),
    .upd_en(live && upd_dr && sel == SEL_BSC),
    .tdi(tdi), .pin_in(pin_in), .so(bsc_so), .latch_out(latch_out)
  );

  // reset register: shift only, cleared by test-logic-reset, no update latch
  jdr_onebit u_rst (
    .tck(tck), .rst_n(rst_n), .clr(tlr), .cap_en(1'b0),
    .shf_en(live && shf_dr && sel == SEL_RST),
    .tdi(tdi), .q(rst_q)
  );

  jdr_onebit u_byp (
    .tck(tck), .rst_n(rst_n), .clr(1'b0),
    .cap_en(live && cap_dr && sel == SEL_BYP),
    .shf_en(live && shf_dr && sel == SEL_BYP),
    .tdi(tdi), .q(byp_q)
  );

  always_comb begin
    unique case (sel)
      SEL_BSC: tdo = bsc_so;
      SEL_RST: tdo = rst_q;
      default: tdo = byp_q;
    endcase
  end

  assign core_rst_req = rst_q;
endmodule

// File: rtl/jdr_checker.sv
module jdr_checker #(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned IR_W   = 4,
  parameter logic [IR_W-1:0] CODE_BSC = 4'h2,
  parameter logic [IR_W-1:0] CODE_RST = 4'hC
) (
  input logic              tck,
  input logic              rst_n,
  input logic              tlr,
  input logic              ir_upd,
  input logic              cap_dr,
  input logic              shf_dr,
  input logic              upd_dr,
  input logic              tdi,
  input logic              tdo,
  input logic [N_PINS-1:0] latch_out,
  input logic              core_rst_req,
  input logic [IR_W-1:0]   cur_instr
);
  logic on_bsc, on_rst;
  assign on_bsc = (cur_instr == CODE_BSC);
  assign on_rst = (cur_instr == CODE_RST);

  p_latch_hold_r4: assert property (@(posedge tck) disable iff (!rst_n)
    !(upd_dr && on_bsc && !tlr) |=> $stable(latch_out));

  p_rst_shift_r5: assert property (@(posedge tck) disable iff (!rst_n)
    (shf_dr && on_rst && !tlr) |=> core_rst_req == $past(tdi));

  p_rst_hold_r6: assert property (@(posedge tck) disable iff (!rst_n)
    (!tlr && !(shf_dr && on_rst)) |=> $stable(core_rst_req));

  p_bypass_zero_r7: assert property (@(posedge tck) disable iff (!rst_n)
    (cap_dr && !tlr && !ir_upd && !on_bsc && !on_rst) |=> !tdo);

  p_tlr_release_r9: assert property (@(posedge tck) disable iff (!rst_n)
    tlr |=> !core_rst_req);
endmodule

bind jtag_dr_select jdr_checker #(
  .N_PINS(N_PINS), .IR_W(IR_W), .CODE_BSC(CODE_BSC), .CODE_RST(CODE_RST)
) u_chk (
  .tck(tck), .rst_n(rst_n), .tlr(tlr), .ir_upd(ir_upd), .cap_dr(cap_dr),
  .shf_dr(shf_dr), .upd_dr(upd_dr), .tdi(tdi), .tdo(tdo), .latch_out(latch_out),
  .core_rst_req(core_rst_req), .cur_instr(cur_instr)
);

// File: tb/jtag_dr_select_tb_top.sv
`timescale 1ns/1ps
module jtag_dr_select_tb_top;
  localparam int NP = 6;

  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic tlr = 1'b0, ir_upd = 1'b0, cap_dr = 1'b0, shf_dr = 1'b0, upd_dr = 1'b0, tdi = 1'b0;
  logic [3:0] ir_code = 4'h0;
  logic [NP-1:0] pin_in = '0;
  logic tdo, core_rst_req;
  logic [NP-1:0] latch_out;

  always #2.5 tck = ~tck;

  jtag_dr_select #(.N_PINS(NP)) dut_i (
    .tck(tck), .rst_n(rst_n), .tlr(tlr), .ir_upd(ir_upd), .ir_code(ir_code),
    .cap_dr(cap_dr), .shf_dr(shf_dr), .upd_dr(upd_dr), .tdi(tdi), .pin_in(pin_in),
    .tdo(tdo), .latch_out(latch_out), .core_rst_req(core_rst_req)
  );

  int n_chk = 0, n_bad = 0;

  // reference state built from the requirements
  logic [3:0]    m_ins = 4'hF;
  logic [NP-1:0] m_chain = '0, m_latch = '0;
  logic          m_rst = 1'b0, m_byp = 1'b0;

  function automatic int sel_of(input logic [3:0] c);
    if (c == 4'h2) return 1;
    if (c == 4'hC) return 2;
    return 0;
  endfunction

  function automatic logic exp_tdo();
    case (sel_of(m_ins))
      1: return m_chain[0];
      2: return m_rst;
      default: return m_byp;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " tdo"}, {31'd0, tdo}, {31'd0, exp_tdo()});
    chk({tag, " latch_out"}, {{(32-NP){1'b0}}, latch_out}, {{(32-NP){1'b0}}, m_latch});
    chk({tag, " core_rst_req"}, {31'd0, core_rst_req}, {31'd0, m_rst});
  endtask

  task automatic model_edge();
    if (tlr) begin
      m_ins = 4'hF;
      m_rst = 1'b0;
    end else begin
      case (sel_of(m_ins))
        1: begin
          if (cap_dr)      m_chain = pin_in;
          else if (shf_dr) m_chain = {tdi, m_chain[NP-1:1]};
          if (upd_dr)      m_latch = m_chain;
        end
        2: if (shf_dr) m_rst = tdi;
        default: begin
          if (cap_dr)      m_byp = 1'b0;
          else if (shf_dr) m_byp = tdi;
        end
      endcase
      if (ir_upd) m_ins = ir_code;
    end
  endtask

  // op: 0 idle, 1 capture, 2 shift, 3 update, 4 load instruction, 5 tlr
  task automatic step(input int op, input logic [3:0] code, input logic d,
                      input logic [NP-1:0] pins, input string tag);
    @(negedge tck);
    tlr = (op == 5); ir_upd = (op == 4); cap_dr = (op == 1);
    shf_dr = (op == 2); upd_dr = (op == 3);
    ir_code = code; tdi = d; pin_in = pins;
    @(posedge tck);
    model_edge();
    #1;
    check_all(tag);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1149));
    repeat (3) @(negedge tck);
    rst_n = 1'b1;
    #1;
    check_all("R1 reset");

    // boundary-scan: capture, shift, update
    step(4, 4'h2, 1'b0, '0, "R2 load");
    step(1, 4'h0, 1'b0, 6'b101101, "R2 capture");
    for (int i = 0; i < NP; i++) step(2, 4'h0, (i % 2) == 0, 6'b010010, "R3 shift");
    step(3, 4'h0, 1'b0, '0, "R4 update");
    step(1, 4'h0, 1'b0, 6'b110011, "R4 capture keeps latch");

    // reset register
    step(4, 4'hC, 1'b0, '0, "R5 load");
    step(2, 4'h0, 1'b1, '0, "R5 shift one");
    step(1, 4'h0, 1'b0, '0, "R5 capture no effect");
    step(3, 4'h0, 1'b0, '0, "R5 update no effect");
    step(4, 4'hF, 1'b0, '0, "R6 instr change");
    step(2, 4'h0, 1'b0, '0, "R6 bypass shift");
    step(5, 4'h0, 1'b0, '0, "R9 tlr");

    // bypass and unknown codes
    step(1, 4'h0, 1'b0, '0, "R7 capture zero");
    step(2, 4'h0, 1'b1, '0, "R7 shift one");
    step(4, 4'h7, 1'b0, '0, "R8 load unknown");
    step(1, 4'h0, 1'b0, '0, "R8 capture");
    step(2, 4'h0, 1'b1, '0, "R8 shift");

    // unselected chain keeps contents
    step(4, 4'h2, 1'b0, '0, "R10 back to chain");
    for (int i = 0; i < NP; i++) step(2, 4'h0, 1'b0, '0, "R10 shift out");

    // tlr overrides a simultaneous load
    step(4, 4'hC, 1'b0, '0, "R9 load rst");
    step(2, 4'h0, 1'b1, '0, "R9 set rst");
    @(negedge tck);
    tlr = 1'b1; ir_upd = 1'b1; ir_code = 4'h2; shf_dr = 1'b0;
    @(posedge tck); model_edge(); #1; check_all("R9 tlr beats load");

    // constrained random mix
    for (int k = 0; k < 2000; k++) begin
      int r;
      int op;
      logic [3:0] c;
      r = $urandom_range(0, 99);
      if (r < 8) op = 4;
      else if (r < 10) op = 5;
      else if (r < 25) op = 1;
      else if (r < 80) op = 2;
      else if (r < 92) op = 3;
      else op = 0;
      c = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15))
        : (($urandom_range(0, 1) == 0) ? 4'h2 : 4'hC);
      step(op, c, 1'($urandom_range(0, 1)), NP'($urandom), "R10 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule